// File: doc/BRIEF.md
# On-Chip Memory Base-Address Decoder

This block decides, for every request on a processor's local bus, whether the request belongs to a small on-chip read-only memory. Software programs a 32-bit window control word through a register port. The word holds a base address, a write-protect flag, a bus-side flag, five per-address-space disable bits and a valid flag. A separate 4-bit size code, tied off at integration, gives the memory size. The size sets how many high address bits take part in the compare.

Each request carries an address, a read/write flag and a space qualifier. The qualifier is CPU space, or a supervisor/user and code/data pair. For each request the block raises exactly one of three outputs: memory selected, forward to the external bus, or access error. An access error is raised for a write to a write-protected window. The reset value of the control word comes from a strap input, so the memory can be live straight out of reset.

The only state is the control register. Its two conditions are invalid (valid bit 0) and live (valid bit 1). A register write moves between them, and reset picks the start condition from the strap.

Top module: `rom_window_decoder`

## Requirements
- R1: The control word is laid out as base in bits 31:9, write-protect in bit 8, bus-side flag in bit 7, a reserved bit 6, disable bits in bits 5:1 and valid in bit 0. The disable bits run from bit 5 to bit 1 in this order: CPU space, supervisor code, supervisor data, user code, user data. Bit 6 always reads back as 0.
- R2: During reset with `strap_live` = 1 the word becomes 0x0000_0121. With `strap_live` = 0 it becomes 0x0000_0000.
- R3: While the valid bit is 0, no request selects the memory or raises an access error. Every valid request goes to the external bus.
- R4: For size code n with 1 ≤ n ≤ MAX_CODE, the window is 2^(n+8) bytes. A request matches when address bits 31:(n+8) equal the same bits of the base, and base bits below n+8 are ignored. Code 0, and any code above MAX_CODE (default 10), never matches.
- R5: A request whose space has its disable bit at 1 does not select the memory and goes to the external bus.
- R6: A matching, enabled write while write-protect is 1 raises `acc_err` only. It asserts neither `mem_sel` nor `ext_bus`.
- R7: While write-protect is 0, matching enabled reads and writes both assert `mem_sel`.
- R8: With `req_valid` = 0, all three decision outputs are 0.
- R9: The decision outputs follow the request combinationally. A register write takes effect for requests in the following clock cycle, and the request in the write's own cycle uses the old word.
- R10: Bit 7 drives `bus_is_instr` and has no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_live | input | 1 | Selects the live reset word |
| size_code | input | 4 | Memory size configuration code |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write value |
| cfg_rd_data | output | 32 | Current control word |
| req_valid | input | 1 | Bus request present |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 1 | CPU-space / interrupt-acknowledge request |
| req_super | input | 1 | 1 = supervisor, 0 = user |
| req_code | input | 1 | 1 = code fetch, 0 = data |
| mem_sel | output | 1 | On-chip memory selected |
| ext_bus | output | 1 | Request passed to external bus |
| acc_err | output | 1 | Access error for protected write |
| bus_is_instr | output | 1 | Bus-side flag from bit 7 |

## Verification
Requests are placed on both sides of each window edge for several size codes. These show whether the compare boundary sits on the right bit, and base bits set below that boundary show that those bits are ignored. Each of the five spaces is disabled in turn while a neighbouring space is also sent, so a wrong bit order shows up as a hit in the wrong space. Reads and writes are sent with write-protect at 1 and at 0, which separates the error path from the select path. Invalid-word, out-of-range-size, idle-request, same-cycle-write and both strap cases cover the remaining routes.

// File: rtl/romwin_pkg.sv
package romwin_pkg;
    localparam int ADDR_W   = 32;
    localparam int BASE_LSB = 9;

    localparam logic [31:0] LIVE_RESET_WORD = 32'h0000_0121;

    // Order of fields matches bit positions 31 down to 0.
    typedef struct packed {
        logic [ADDR_W-BASE_LSB-1:0] base;
        logic                       wprot;
        logic                       instr_side;
        logic                       rsvd;
        logic [4:0]                 space_off;
        logic                       live;
    } win_cfg_t;

    // Value equals the index into space_off.
    typedef enum logic [2:0] {
        SPACE_USER_DATA  = 3'd0,
        SPACE_USER_CODE  = 3'd1,
        SPACE_SUPER_DATA = 3'd2,
        SPACE_SUPER_CODE = 3'd3,
        SPACE_CPU        = 3'd4
    } space_e;
endpackage

// File: rtl/romwin_cfg_reg.sv
module romwin_cfg_reg
    import romwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_live,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output win_cfg_t    cfg_o
);
    win_cfg_t cfg_q;
    win_cfg_t wr_word;

    always_comb begin
        wr_word      = win_cfg_t'(wr_data);
        wr_word.rsvd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= strap_live ? win_cfg_t'(LIVE_RESET_WORD) : win_cfg_t'('0);
        end else if (wr_en) begin
            cfg_q <= wr_word;
        end
    end

    assign cfg_o = cfg_q;

    // R9: without a write strobe the word holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
    // R1: reserved bit stays clear after any write
    p_rsvd_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q.rsvd == 1'b0));
endmodule

// File: rtl/romwin_size_mask.sv
module romwin_size_mask
    import romwin_pkg::*;
#(
    parameter int MAX_CODE = 10
) (
    input  logic [3:0]        size_code,
    output logic [ADDR_W-1:0] cmp_mask,
    output logic              size_ok
);
    localparam int LSB_OFFSET = BASE_LSB - 1;

    assign size_ok = (size_code != 4'd0) && (int'(size_code) <= MAX_CODE);

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b < BASE_LSB) begin : g_low
            assign cmp_mask[b] = 1'b0;
        end else begin : g_cmp
            assign cmp_mask[b] = size_ok && (b >= int'(size_code) + LSB_OFFSET);
        end
    end
endmodule

// File: rtl/romwin_space_sel.sv
module romwin_space_sel
    import romwin_pkg::*;
(
    input  logic       req_cpu,
    input  logic       req_super,
    input  logic       req_code,
    input  logic [4:0] space_off,
    output logic       blocked
);
    space_e space;

    always_comb begin
        unique case ({req_cpu, req_super, req_code})
            3'b000:  space = SPACE_USER_DATA;
            3'b001:  space = SPACE_USER_CODE;
            3'b010:  space = SPACE_SUPER_DATA;
            3'b011:  space = SPACE_SUPER_CODE;
            default: space = SPACE_CPU;
        endcase
    end

    assign blocked = space_off[space];
endmodule

// File: rtl/romwin_route.sv
module romwin_route (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic live,
    input  logic size_ok,
    input  logic addr_match,
    input  logic blocked,
    input  logic wprot,
    output logic mem_sel,
    output logic ext_bus,
    output logic acc_err
);
    logic claim;

    always_comb begin
        claim   = req_valid && live && size_ok && addr_match && !blocked;
        acc_err = claim && req_write && wprot;
        mem_sel = claim && !acc_err;
        ext_bus = req_valid && !claim;
    end

    // R6: select and error are exclusive
    p_sel_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_sel && acc_err));
    // R6: errored requests are not forwarded
    p_err_not_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> !ext_bus);
    // R3: an invalid word never claims
    p_dead_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> !(mem_sel || acc_err));
    // R8: idle bus, quiet outputs
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(mem_sel || ext_bus || acc_err));
    // R4: bad size code never selects
    p_badsize_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !size_ok |-> !mem_sel);
endmodule

// File: rtl/rom_window_decoder.sv
module rom_window_decoder
    import romwin_pkg::*;
#(
    parameter int MAX_CODE = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_live,
    input  logic [3:0]  size_code,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic        req_cpu,
    input  logic        req_super,
    input  logic        req_code,
    output logic        mem_sel,
    output logic        ext_bus,
    output logic        acc_err,
    output logic        bus_is_instr
);
    win_cfg_t          cfg;
    logic [ADDR_W-1:0] cmp_mask;
    logic              size_ok;
    logic              blocked;
    logic              addr_match;
    logic [ADDR_W-1:0] base_addr;

    romwin_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_live (strap_live),
        .wr_en      (cfg_wr_en),
        .wr_data    (cfg_wr_data),
        .cfg_o      (cfg)
    );

    romwin_size_mask #(.MAX_CODE(MAX_CODE)) u_size (
        .size_code (size_code),
        .cmp_mask  (cmp_mask),
        .size_ok   (size_ok)
    );

    romwin_space_sel u_space (
        .req_cpu   (req_cpu),
        .req_super (req_super),
        .req_code  (req_code),
        .space_off (cfg.space_off),
        .blocked   (blocked)
    );

    assign base_addr  = {cfg.base, {BASE_LSB{1'b0}}};
    assign addr_match = ((req_addr ^ base_addr) & cmp_mask) == '0;

    romwin_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .live       (cfg.live),
        .size_ok    (size_ok),
        .addr_match (addr_match),
        .blocked    (blocked),
        .wprot      (cfg.wprot),
        .mem_sel    (mem_sel),
        .ext_bus    (ext_bus),
        .acc_err    (acc_err)
    );

    assign cfg_rd_data  = 32'(cfg);
    assign bus_is_instr = cfg.instr_side;
endmodule

// File: tb/rom_window_decoder_tb_top.sv
module rom_window_decoder_tb_top;
    localparam int MAXC = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        strap_live = 1;
    logic [3:0]  size_code = 4'd1;
    logic        cfg_wr_en = 0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 0;
    logic [31:0] req_addr = '0;
    logic        req_write = 0, req_cpu = 0, req_super = 0, req_code = 0;
    logic        mem_sel, ext_bus, acc_err, bus_is_instr;

    int total = 0, bad = 0, cycles = 0;
    logic [31:0] model = '0;
    logic [2:0]  exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    rom_window_decoder #(.MAX_CODE(MAXC)) dut_i (.*);

    function automatic logic [2:0] predict(logic [31:0] w, logic [3:0] sc, logic v,
                                           logic [31:0] a, logic wr, logic c, logic s, logic cd);
        int  low;
        int  idx;
        logic hit, err;
        low = int'(sc) + 8;
        idx = c ? 5 : (s ? (cd ? 4 : 3) : (cd ? 2 : 1));
        hit = v && w[0] && sc != 0 && int'(sc) <= MAXC && ((a >> low) == (w >> low)) && !w[idx];
        err = hit && wr && w[8];
        return {hit && !err, v && !hit, err};   // {sel, ext, err}
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(string tag, logic v, logic [31:0] a, logic wr, logic c, logic s, logic cd);
        @(negedge clk);
        req_valid = v; req_addr = a; req_write = wr; req_cpu = c; req_super = s; req_code = cd;
        exp_q.push_back(predict(model, size_code, v, a, wr, c, s, cd));
        tag_q.push_back(tag);
    endtask

    task automatic cfg_write(logic [31:0] w);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_data = w;
        @(negedge clk);
        cfg_wr_en = 0;
        model = w & ~32'h40;
    endtask

    // monitor: compares each driven request a little after it is applied
    always begin
        @(negedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {29'd0, mem_sel, ext_bus, acc_err}, {29'd0, e});
        end
    end

    task automatic do_reset(logic strap);
        @(negedge clk);
        strap_live = strap; rst_n = 0; req_valid = 0;
        model = strap ? 32'h121 : 32'h0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1 check(strap ? "R2 live reset word" : "R2 cleared reset word", cfg_rd_data, model);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog R9 act=%0d exp<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset(1);
        size_code = 4'd1;
        drive("R4 top of 512B window", 1, 32'h0000_01FC, 0, 0, 1, 0);
        drive("R4 just past window", 1, 32'h0000_0200, 0, 0, 1, 0);
        drive("R5 cpu space masked at reset", 1, 32'h0, 0, 1, 0, 0);
        drive("R6 protected write", 1, 32'h10, 1, 0, 0, 1);
        drive("R8 idle request", 0, 32'h0, 1, 0, 1, 0);

        cfg_write(32'hFFFF_FFFF);
        #1 check("R1 reserved bit reads 0", cfg_rd_data, 32'hFFFF_FFBF);

        cfg_write(32'h0004_0081);
        #1 check("R10 bus side flag", {31'd0, bus_is_instr}, 32'd1);
        size_code = 4'd5;
        drive("R7 write allowed, R10 no effect", 1, 32'h0004_1FFF, 1, 0, 0, 0);
        drive("R4 above 8KB window", 1, 32'h0004_2000, 0, 0, 0, 0);
        cfg_write(32'h0004_1E01);
        drive("R4 low base bits ignored", 1, 32'h0004_0000, 0, 0, 1, 1);
        size_code = 4'd10;
        drive("R4 max code inside", 1, 32'h0007_FFFF, 0, 0, 1, 1);
        drive("R4 max code outside", 1, 32'h0008_0000, 0, 0, 1, 1);
        size_code = 4'd11;
        drive("R4 code beyond max", 1, 32'h0004_0000, 0, 0, 1, 1);
        size_code = 4'd0;
        drive("R4 zero size", 1, 32'h0004_0000, 0, 0, 1, 1);
        size_code = 4'd3;

        for (int k = 1; k <= 5; k++) begin
            cfg_write(32'h0004_0001 | (32'd1 << k));
            drive("R5 space mask sweep UD", 1, 32'h0004_0100, 0, 0, 0, 0);
            drive("R5 space mask sweep UC", 1, 32'h0004_0100, 0, 0, 0, 1);
            drive("R5 space mask sweep SD", 1, 32'h0004_0100, 1, 0, 1, 0);
            drive("R5 space mask sweep SC", 1, 32'h0004_0100, 0, 0, 1, 1);
            drive("R5 space mask sweep CPU", 1, 32'h0004_0100, 0, 1, 0, 0);
        end

        cfg_write(32'h0004_0000);
        drive("R3 invalid word forwards", 1, 32'h0004_0000, 0, 0, 1, 0);

        // R9: write and request in the same cycle use the old word
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_data = 32'h0004_0101;
        req_valid = 1; req_addr = 32'h0004_0004; req_write = 1;
        req_cpu = 0; req_super = 1; req_code = 0;
        exp_q.push_back(predict(model, size_code, 1, 32'h0004_0004, 1, 0, 1, 0));
        tag_q.push_back("R9 same-cycle uses old word");
        @(negedge clk);
        cfg_wr_en = 0;
        model = 32'h0004_0101;
        exp_q.push_back(predict(model, size_code, 1, 32'h0004_0004, 1, 0, 1, 0));
        tag_q.push_back("R9 next cycle uses new word");

        do_reset(0);
        drive("R3 cleared reset forwards", 1, 32'h0, 0, 0, 1, 0);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule